// File: doc/BRIEF.md
# Two-Queue Triggered Conversion Sequencer

This block walks a 64-entry table of conversion commands on behalf of two queues and hands one conversion at a time to an external converter. Each table entry carries a channel number and a pause bit. The table itself lives outside the block, and each queue has its own combinational read port into it. Queue 1 always scans from entry 0. Queue 2 scans from an entry chosen by an input.

Each queue has a mode bit that selects its trigger source. In gate mode, a scan starts when the queue is enabled and its gate input is high. The scan stops cleanly if the gate drops. In timer mode, a single interval timer shared by both queues starts a scan, and later restarts the scan after each pause entry. A scan-enable bit arms a queue for exactly one scan, and the block clears that bit when the scan ends.

Each queue also has a pause flag, an overrun flag and a pointer to the last entry it completed. Software clears the flags by writing a one to them. The converter side uses a request/done handshake, and queue 1 has fixed priority over queue 2.

Top module: `convq_sequencer`

## Requirements
- R1: During and after reset, all scan enables, pause flags, overrun flags and last-entry pointers read 0, and `conv_req` is low.
- R2: The timer interval is 128 clock periods shifted left by `ivl_sel`. The timer starts counting on the edge that registers a scan-enable set in timer mode. The first `conv_req` of that scan is high after exactly interval+2 rising edges.
- R3: Every new scan begins at the queue's first entry: entry 0 for queue 1 and `q2_first` for queue 2. This holds even after a scan that stopped early.
- R4: In timer mode, an entry whose bit 6 (pause) is set is converted. The queue then sets its pause flag and issues nothing further until the next timer elapse. After that elapse it continues with the following entry. Gate mode ignores the pause bit.
- R5: An entry ends the scan without a conversion if its channel field (bits 5:0) is 63, or if the index has passed entry 63. Ending the scan clears the queue's scan enable. After that, the timer issues no further triggers for that queue until the enable is set again.
- R6: A timer elapse that arrives while a timer-mode queue is running or converting sets that queue's overrun flag.
- R7: The timer keeps counting without restart while any timer-mode queue is enabled. It returns to zero only when no timer-mode queue is enabled.
- R8: In gate mode, if the gate drops during a conversion, that conversion completes. The queue then stops, clears its scan enable and sets its pause flag. No further entry is issued.
- R9: On each completed conversion, the queue's last-entry pointer takes the index of that entry.
- R10: At most one conversion is outstanding at a time. When both queues have an entry ready, queue 1 is served first, and queue 2 waits until queue 1 has no entry ready or in progress.
- R11: A one on a flag-clear input clears the matching flag. A pause flag that is still set does not prevent a new scan once the enable is set again.
- R12: `conv_req` and `conv_chan` are held steady from the start of a conversion until `conv_done` is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ivl_sel | input | 4 | Timer interval select: interval = 128 << ivl_sel |
| q_timer_mode | input | 2 | Per queue: 1 = timer trigger, 0 = gate trigger |
| q_gate | input | 2 | Per-queue gate inputs (1 = open) |
| q_scan_set | input | 2 | Pulse to set the queue's scan enable |
| q_pause_clr | input | 2 | Write-one-to-clear for the pause flags |
| q_ovr_clr | input | 2 | Write-one-to-clear for the overrun flags |
| q2_first | input | 6 | First table entry of queue 2 |
| tbl_addr_q1 | output | 6 | Table index read for queue 1 |
| tbl_data_q1 | input | 7 | Table entry at tbl_addr_q1: bit 6 pause, bits 5:0 channel |
| tbl_addr_q2 | output | 6 | Table index read for queue 2 |
| tbl_data_q2 | input | 7 | Table entry at tbl_addr_q2 |
| conv_req | output | 1 | Conversion in progress request |
| conv_chan | output | 6 | Channel to convert |
| conv_qsel | output | 1 | Queue owning the request (0 = queue 1) |
| conv_done | input | 1 | Single-cycle conversion-complete pulse |
| q_scan_en | output | 2 | Per-queue scan enables |
| q_pause_flag | output | 2 | Per-queue pause flags |
| q_ovr_flag | output | 2 | Per-queue overrun flags |
| q1_last_idx | output | 6 | Last completed entry of queue 1 |
| q2_last_idx | output | 6 | Last completed entry of queue 2 |

## Verification
The embedded properties check the following local rules on every cycle:
- only one conversion is ever outstanding, and queue 1 wins a tie;
- the request and channel hold until done;
- an end entry drops the enable;
- a gate drop outside a conversion stops the queue with its pause flag set;
- a trigger that arrives while running raises overrun;
- a paused queue stays paused without a trigger;
- the timer stays cleared while no timer queue is armed.

Other behaviours span many cycles and need the bench's scenarios to show them:
- the exact trigger latency at several interval selections;
- the shared timer running on after one queue ends, seen in the resume time of the other queue;
- a conversion that is allowed to finish after its gate drops;
- the last-entry pointer after an early stop;
- restarting from the first entry;
- the end condition past entry 63.

// File: rtl/convq_pkg.sv
package convq_pkg;

   typedef enum logic [1:0] {
      QS_IDLE  = 2'd0,
      QS_RUN   = 2'd1,
      QS_CONV  = 2'd2,
      QS_PAUSE = 2'd3
   } qstate_e;

   localparam int NUM_Q = 2;

endpackage

// File: rtl/convq_interval_timer.sv
module convq_interval_timer #(
   parameter int BASE_DIV = 128,
   parameter int MAX_SEL  = 10,
   parameter int SEL_W    = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             active,
   input  logic [SEL_W-1:0] sel,
   output logic             tick
);
   localparam int BASE_LOG = $clog2(BASE_DIV);
   localparam int CNT_W    = BASE_LOG + MAX_SEL;
   localparam logic [CNT_W:0] BASE_V = (CNT_W+1)'(BASE_DIV);
   localparam logic [SEL_W-1:0] SEL_CAP = SEL_W'(MAX_SEL);

   if (BASE_DIV != (1 << BASE_LOG)) begin : g_chk_base
      $error("BASE_DIV must be a power of two");
   end
   if (MAX_SEL >= (1 << SEL_W)) begin : g_chk_sel
      $error("MAX_SEL does not fit in SEL_W bits");
   end

   logic [SEL_W-1:0] sel_c;
   logic [CNT_W:0]   limit;
   logic [CNT_W-1:0] count;
   logic             at_end;

   // Select values beyond the largest interval are clamped to it.
   assign sel_c  = (sel > SEL_CAP) ? SEL_CAP : sel;
   assign limit  = BASE_V << sel_c;
   assign at_end = ({1'b0, count} == (limit - 1'b1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count <= '0;
         tick  <= 1'b0;
      end else if (!active) begin
         count <= '0;
         tick  <= 1'b0;
      end else if (at_end) begin
         count <= '0;
         tick  <= 1'b1;
      end else begin
         count <= count + 1'b1;
         tick  <= 1'b0;
      end
   end

   // R7: the timer is held cleared while no timer-mode queue is armed
   a_r7_idle_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      !active |=> (count == '0) && !tick);

   // R2: a trigger only follows a cycle in which counting was enabled
   a_r2_tick_needs_active: assert property (@(posedge clk) disable iff (!rst_n)
      tick |-> $past(active));

endmodule

// File: rtl/convq_queue_fsm.sv
module convq_queue_fsm
   import convq_pkg::*;
#(
   parameter int IDX_W  = 6,
   parameter int CHAN_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_timer,
   input  logic              gate_open,
   input  logic              ss_set,
   input  logic              pause_clr,
   input  logic              ovr_clr,
   input  logic              trig,
   input  logic [IDX_W-1:0]  start_idx,
   input  logic              entry_pause,
   input  logic [CHAN_W-1:0] entry_chan,
   input  logic              grant,
   input  logic              done,
   output logic [IDX_W-1:0]  rd_idx,
   output logic              want,
   output logic              in_conv,
   output logic              ss_en,
   output logic              pause_flag,
   output logic              ovr_flag,
   output logic [IDX_W-1:0]  last_idx
);
   localparam logic [CHAN_W-1:0] EOQ_CODE = {CHAN_W{1'b1}};

   if (IDX_W < 1 || CHAN_W < 1) begin : g_chk_w
      $error("queue widths must be positive");
   end

   qstate_e        state;
   logic [IDX_W:0] idx;
   logic           entry_eoq;
   logic           gate_stop;
   logic           running;

   assign entry_eoq = idx[IDX_W] || (entry_chan == EOQ_CODE);
   assign gate_stop = !mode_timer && !gate_open;
   assign running   = (state == QS_RUN) || (state == QS_CONV);
   assign want      = (state == QS_RUN) && !entry_eoq && !gate_stop;
   assign in_conv   = (state == QS_CONV);
   assign rd_idx    = idx[IDX_W-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state      <= QS_IDLE;
         idx        <= '0;
         ss_en      <= 1'b0;
         pause_flag <= 1'b0;
         ovr_flag   <= 1'b0;
         last_idx   <= '0;
      end else begin
         if (pause_clr) pause_flag <= 1'b0;
         if (ovr_clr)   ovr_flag   <= 1'b0;
         if (ss_set)    ss_en      <= 1'b1;
         if (trig && mode_timer && running) ovr_flag <= 1'b1;

         unique case (state)
            QS_IDLE: begin
               if (ss_en && (mode_timer ? trig : gate_open)) begin
                  state <= QS_RUN;
                  idx   <= {1'b0, start_idx};
               end
            end
            QS_RUN: begin
               if (gate_stop) begin
                  state      <= QS_IDLE;
                  ss_en      <= 1'b0;
                  pause_flag <= 1'b1;
               end else if (entry_eoq) begin
                  state <= QS_IDLE;
                  ss_en <= 1'b0;
               end else if (grant) begin
                  state <= QS_CONV;
               end
            end
            QS_CONV: begin
               if (done) begin
                  last_idx <= idx[IDX_W-1:0];
                  if (mode_timer && entry_pause) begin
                     state      <= QS_PAUSE;
                     pause_flag <= 1'b1;
                  end else if (gate_stop) begin
                     state      <= QS_IDLE;
                     ss_en      <= 1'b0;
                     pause_flag <= 1'b1;
                  end else begin
                     state <= QS_RUN;
                     idx   <= idx + 1'b1;
                  end
               end
            end
            QS_PAUSE: begin
               if (trig) begin
                  state <= QS_RUN;
                  idx   <= idx + 1'b1;
               end
            end
            default: state <= QS_IDLE;
         endcase
      end
   end

   // R5: an end entry leaves the queue idle with its enable dropped
   a_r5_eoq_ends: assert property (@(posedge clk) disable iff (!rst_n)
      (state == QS_RUN && entry_eoq && !gate_stop) |=> (!ss_en && state == QS_IDLE));

   // R8: a closed gate between conversions stops the scan and flags it
   a_r8_gate_stop: assert property (@(posedge clk) disable iff (!rst_n)
      (state == QS_RUN && gate_stop) |=> (!ss_en && pause_flag));

   // R6: a trigger while busy is recorded as overrun
   a_r6_overrun: assert property (@(posedge clk) disable iff (!rst_n)
      (trig && mode_timer && running) |=> ovr_flag);

   // R4: a paused queue waits for the next trigger
   a_r4_pause_wait: assert property (@(posedge clk) disable iff (!rst_n)
      (state == QS_PAUSE && !trig) |=> (state == QS_PAUSE));

   // R12: a conversion in progress is held until done
   a_r12_conv_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (state == QS_CONV && !done) |=> (state == QS_CONV));

endmodule

// File: rtl/convq_sequencer.sv
module convq_sequencer
   import convq_pkg::*;
#(
   parameter int IDX_W    = 6,
   parameter int CHAN_W   = 6,
   parameter int SEL_W    = 4,
   parameter int BASE_DIV = 128,
   parameter int MAX_SEL  = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SEL_W-1:0]  ivl_sel,
   input  logic [1:0]        q_timer_mode,
   input  logic [1:0]        q_gate,
   input  logic [1:0]        q_scan_set,
   input  logic [1:0]        q_pause_clr,
   input  logic [1:0]        q_ovr_clr,
   input  logic [IDX_W-1:0]  q2_first,
   output logic [IDX_W-1:0]  tbl_addr_q1,
   input  logic [CHAN_W:0]   tbl_data_q1,
   output logic [IDX_W-1:0]  tbl_addr_q2,
   input  logic [CHAN_W:0]   tbl_data_q2,
   output logic              conv_req,
   output logic [CHAN_W-1:0] conv_chan,
   output logic              conv_qsel,
   input  logic              conv_done,
   output logic [1:0]        q_scan_en,
   output logic [1:0]        q_pause_flag,
   output logic [1:0]        q_ovr_flag,
   output logic [IDX_W-1:0]  q1_last_idx,
   output logic [IDX_W-1:0]  q2_last_idx
);
   localparam int CMD_W = CHAN_W + 1;

   logic [CMD_W-1:0] entry   [NUM_Q];
   logic [IDX_W-1:0] rd_idx  [NUM_Q];
   logic [IDX_W-1:0] last    [NUM_Q];
   logic [NUM_Q-1:0] want;
   logic [NUM_Q-1:0] in_conv;
   logic [NUM_Q-1:0] grant;
   logic [NUM_Q-1:0] done_q;
   logic             any_conv;
   logic             timer_active;
   logic             tick;

   assign entry[0] = tbl_data_q1;
   assign entry[1] = tbl_data_q2;
   assign tbl_addr_q1 = rd_idx[0];
   assign tbl_addr_q2 = rd_idx[1];
   assign q1_last_idx = last[0];
   assign q2_last_idx = last[1];

   assign timer_active = |(q_scan_en & q_timer_mode);

   convq_interval_timer #(
      .BASE_DIV (BASE_DIV),
      .MAX_SEL  (MAX_SEL),
      .SEL_W    (SEL_W)
   ) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .active (timer_active),
      .sel    (ivl_sel),
      .tick   (tick)
   );

   // Fixed priority: queue 1 first, one conversion at a time.
   assign any_conv = |in_conv;
   assign grant[0] = want[0] && !any_conv;
   assign grant[1] = want[1] && !want[0] && !any_conv;
   assign done_q   = in_conv & {NUM_Q{conv_done}};

   for (genvar gi = 0; gi < NUM_Q; gi++) begin : g_q
      convq_queue_fsm #(
         .IDX_W  (IDX_W),
         .CHAN_W (CHAN_W)
      ) u_q (
         .clk         (clk),
         .rst_n       (rst_n),
         .mode_timer  (q_timer_mode[gi]),
         .gate_open   (q_gate[gi]),
         .ss_set      (q_scan_set[gi]),
         .pause_clr   (q_pause_clr[gi]),
         .ovr_clr     (q_ovr_clr[gi]),
         .trig        (tick),
         .start_idx   ((gi == 0) ? {IDX_W{1'b0}} : q2_first),
         .entry_pause (entry[gi][CMD_W-1]),
         .entry_chan  (entry[gi][CHAN_W-1:0]),
         .grant       (grant[gi]),
         .done        (done_q[gi]),
         .rd_idx      (rd_idx[gi]),
         .want        (want[gi]),
         .in_conv     (in_conv[gi]),
         .ss_en       (q_scan_en[gi]),
         .pause_flag  (q_pause_flag[gi]),
         .ovr_flag    (q_ovr_flag[gi]),
         .last_idx    (last[gi])
      );
   end

   assign conv_req  = any_conv;
   assign conv_qsel = in_conv[1];
   assign conv_chan = in_conv[1] ? entry[1][CHAN_W-1:0] : entry[0][CHAN_W-1:0];

   // R10: the two queues never convert at once
   a_r10_single_conv: assert property (@(posedge clk) disable iff (!rst_n)
      !(in_conv[0] && in_conv[1]));

   // R10: on a tie queue 1 takes the converter
   a_r10_q1_first: assert property (@(posedge clk) disable iff (!rst_n)
      (want[0] && want[1] && !conv_req) |=> (conv_req && !conv_qsel));

   // R12: request and channel stay put until done
   a_r12_req_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_req && !conv_done) |=> (conv_req && $stable(conv_chan)));

endmodule

// File: tb/tb_convq_sequencer.sv
module tb_convq_sequencer;
   localparam int CLK_PERIOD = 10;
   localparam logic [6:0] EOQ = 7'h3F;
   localparam int NVEC = 4;
   localparam int VEC_SEL [NVEC] = '{0, 1, 2, 3};
   localparam int VEC_LAT [NVEC] = '{130, 258, 514, 1026};

   logic clk = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic       rst_n;
   logic [3:0] ivl_sel;
   logic [1:0] q_timer_mode, q_gate, q_scan_set, q_pause_clr, q_ovr_clr;
   logic [5:0] q2_first;
   logic [5:0] tbl_addr_q1, tbl_addr_q2;
   logic [6:0] tbl_data_q1, tbl_data_q2;
   logic       conv_req, conv_qsel, conv_done;
   logic [5:0] conv_chan;
   logic [1:0] q_scan_en, q_pause_flag, q_ovr_flag;
   logic [5:0] q1_last_idx, q2_last_idx;

   logic [6:0] tbl [0:63];
   assign tbl_data_q1 = tbl[tbl_addr_q1];
   assign tbl_data_q2 = tbl[tbl_addr_q2];

   convq_sequencer dut (
      .clk(clk), .rst_n(rst_n), .ivl_sel(ivl_sel), .q_timer_mode(q_timer_mode),
      .q_gate(q_gate), .q_scan_set(q_scan_set), .q_pause_clr(q_pause_clr),
      .q_ovr_clr(q_ovr_clr), .q2_first(q2_first),
      .tbl_addr_q1(tbl_addr_q1), .tbl_data_q1(tbl_data_q1),
      .tbl_addr_q2(tbl_addr_q2), .tbl_data_q2(tbl_data_q2),
      .conv_req(conv_req), .conv_chan(conv_chan), .conv_qsel(conv_qsel),
      .conv_done(conv_done), .q_scan_en(q_scan_en), .q_pause_flag(q_pause_flag),
      .q_ovr_flag(q_ovr_flag), .q1_last_idx(q1_last_idx), .q2_last_idx(q2_last_idx)
   );

   int checks = 0;
   int fails  = 0;
   int done_delay = 3;
   int log_n = 0;
   int log_q  [0:255];
   int log_ch [0:255];

   // Converter model: accepts a request, answers done_delay+1 negedges later.
   initial begin
      bit busy;
      int cnt;
      busy = 0;
      cnt = 0;
      conv_done = 1'b0;
      forever begin
         @(negedge clk);
         conv_done = 1'b0;
         if (conv_req && !busy) begin
            busy = 1;
            cnt = done_delay;
            if (log_n < 256) begin
               log_q[log_n]  = int'(conv_qsel);
               log_ch[log_n] = int'(conv_chan);
            end
            log_n++;
         end else if (busy) begin
            if (cnt == 0) begin
               conv_done = 1'b1;
               busy = 0;
            end else begin
               cnt--;
            end
         end
      end
   end

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic set_scan(logic [1:0] m);
      @(negedge clk) q_scan_set = m;
      @(negedge clk) q_scan_set = 2'b00;
   endtask

   task automatic wait_idle(int q);
      int g = 0;
      while (q_scan_en[q] && g < 5000) begin
         @(negedge clk);
         g++;
      end
   endtask

   task automatic wait_log(int target);
      int g = 0;
      while (log_n < target && g < 5000) begin
         @(negedge clk);
         #1;
         g++;
      end
   endtask

   task automatic clear_tbl();
      for (int i = 0; i < 64; i++) tbl[i] = EOQ;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired (all requirements) actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      int n;
      int base;
      rst_n = 1'b0;
      ivl_sel = '0;
      q_timer_mode = '0; q_gate = '0; q_scan_set = '0;
      q_pause_clr = '0; q_ovr_clr = '0;
      q2_first = 6'd32;
      clear_tbl();
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 scan_en", int'(q_scan_en), 0);
      chk("R1 flags", int'({q_pause_flag, q_ovr_flag}), 0);
      chk("R1 conv_req", int'(conv_req), 0);
      chk("R1 last", int'({q1_last_idx, q2_last_idx}), 0);
      rst_n = 1'b1;

      // R2/R3/R5: vector table of interval selections and trigger latency
      tbl[0] = 7'd5;
      tbl[1] = EOQ;
      q_timer_mode = 2'b01;
      for (int v = 0; v < NVEC; v++) begin
         ivl_sel = 4'(VEC_SEL[v]);
         @(negedge clk) q_scan_set = 2'b01;
         @(posedge clk);
         @(negedge clk) q_scan_set = 2'b00;
         n = 0;
         while (!conv_req && n < 5000) begin
            @(posedge clk);
            n++;
            @(negedge clk);
         end
         chk("R2 latency", n, VEC_LAT[v]);
         chk("R3 first entry chan", int'(conv_chan), 5);
         wait_idle(0);
         chk("R5 enable cleared at end", int'(q_scan_en[0]), 0);
      end
      // R5: no further triggers after the end of queue
      ivl_sel = 4'd0;
      base = log_n;
      repeat (400) @(negedge clk);
      chk("R5 timer halted", log_n - base, 0);

      // R6: overrun while a slow conversion is in progress
      done_delay = 300;
      set_scan(2'b01);
      wait_idle(0);
      chk("R6 overrun set", int'(q_ovr_flag[0]), 1);
      @(negedge clk) q_ovr_clr = 2'b01;
      @(negedge clk) q_ovr_clr = 2'b00;
      chk("R11 overrun cleared", int'(q_ovr_flag[0]), 0);
      done_delay = 3;
      repeat (5) @(negedge clk);

      // R4/R7/R10: shared timer, queue 2 pauses and resumes on the next elapse
      clear_tbl();
      tbl[0] = 7'd1;
      tbl[32] = 7'h4A;   // pause bit with channel 10
      tbl[33] = 7'd11;
      q_timer_mode = 2'b11;
      base = log_n;
      @(negedge clk) q_scan_set = 2'b11;
      @(posedge clk);
      @(negedge clk) q_scan_set = 2'b00;
      n = 0;
      while (!(conv_req && conv_qsel && conv_chan == 6'd11) && n < 5000) begin
         @(posedge clk);
         n++;
         @(negedge clk);
      end
      chk("R7 timer not reset by first end", n, 258);
      wait_idle(1);
      wait_idle(0);
      chk("R10 queue 1 served first", log_q[base], 0);
      chk("R10 queue 1 chan", log_ch[base], 1);
      chk("R4 paused entry converted", log_ch[base+1], 10);
      chk("R4 resumed at next entry", log_ch[base+2], 11);
      chk("R4 conversion count", log_n - base, 3);
      chk("R4 pause flag", int'(q_pause_flag[1]), 1);
      @(negedge clk) q_pause_clr = 2'b10;
      @(negedge clk) q_pause_clr = 2'b00;
      chk("R11 pause cleared", int'(q_pause_flag[1]), 0);

      // R8/R9/R12/R3/R11: gate closes during the third conversion of queue 2
      clear_tbl();
      for (int i = 0; i < 4; i++) tbl[32+i] = 7'(10 + i);
      q_timer_mode = 2'b00;
      done_delay = 20;
      base = log_n;
      set_scan(2'b10);
      @(negedge clk) q_gate = 2'b10;
      wait_log(base + 1);
      repeat (10) @(negedge clk);
      chk("R12 request held", int'(conv_req), 1);
      chk("R12 channel held", int'(conv_chan), 10);
      wait_log(base + 3);
      q_gate = 2'b00;
      repeat (60) @(negedge clk);
      chk("R8 in-flight conversion only", log_n - base, 3);
      chk("R8 enable cleared", int'(q_scan_en[1]), 0);
      chk("R8 pause flag", int'(q_pause_flag[1]), 1);
      chk("R9 last index after stop", int'(q2_last_idx), 34);
      set_scan(2'b10);
      @(negedge clk) q_gate = 2'b10;
      wait_log(base + 4);
      chk("R3 restart at first entry", log_ch[base+3], 10);
      wait_idle(1);
      chk("R11 full scan despite pause flag", log_n - base, 7);
      chk("R9 last index after full scan", int'(q2_last_idx), 35);
      @(negedge clk) q_gate = 2'b00;
      q_pause_clr = 2'b10;
      @(negedge clk) q_pause_clr = 2'b00;
      done_delay = 3;

      // R5/R9: running past the last table index ends the queue
      q2_first = 6'd62;
      tbl[62] = 7'd20;
      tbl[63] = 7'd21;
      base = log_n;
      set_scan(2'b10);
      @(negedge clk) q_gate = 2'b10;
      wait_idle(1);
      chk("R5 end past last index", log_n - base, 2);
      chk("R9 last index 63", int'(q2_last_idx), 63);
      chk("R5 no pause flag at end", int'(q_pause_flag[1]), 0);
      @(negedge clk) q_gate = 2'b00;
      q2_first = 6'd32;

      // R10: both gate queues open together
      clear_tbl();
      tbl[0] = 7'd1; tbl[1] = 7'd2;
      tbl[32] = 7'd10; tbl[33] = 7'd11;
      base = log_n;
      set_scan(2'b11);
      @(negedge clk) q_gate = 2'b11;
      wait_idle(0);
      wait_idle(1);
      chk("R10 order q", log_q[base] + 2*log_q[base+1] + 4*log_q[base+2] + 8*log_q[base+3], 12);
      chk("R10 order chan q2 first", log_ch[base+2], 10);
      chk("R10 total", log_n - base, 4);
      @(negedge clk) q_gate = 2'b00;

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule